// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is one timer channel on a simple register bus. Software writes a start value, picks one of two externally generated tick-enable inputs, and chooses between periodic operation (reload from the stored start value on underflow) and free-running operation (wrap to the all-ones maximum). On each selected tick, while counting is enabled, the counter steps down by one. Each underflow raises a level interrupt that stays up until software writes any value to the clear register.

The count width is a parameter, with 16 bits for narrow channels and 32 bits for a wide one. The bus has four word registers at fixed offsets:

- start value at 0x0
- live count at 0x4, read-only
- control at 0x8
- interrupt clear at 0xC, write-only

Read data is combinational from the selected register. A write takes effect at the clock edge on which the write strobe is sampled.

Top module: `dctimer_chan`

## Requirements
- R1: After reset the start value, live count and control all read 0, and the interrupt output is low.
- R2: A write to offset 0x0 stores the low WIDTH bits of the write data as the start value and also copies them into the counter. Both are readable on the next cycle, at 0x0 and 0x4 respectively.
- R3: While control bit 7 is 0, the counter holds its value whatever the tick inputs do.
- R4: Control bit 3 selects the tick source. With bit 3 set to 1 the counter advances only on the fast tick input. With bit 3 set to 0 it advances only on the slow tick input. The unselected input has no effect.
- R5: With counting enabled, each selected tick with a nonzero count lowers the count by exactly one.
- R6: With control bit 6 set to 1 (periodic), a selected tick at count 0 loads the counter from the start value.
- R7: With control bit 6 set to 0 (free-running), a selected tick at count 0 sets the counter to all ones.
- R8: A selected tick at count 0 is an underflow. It sets the interrupt output on the next cycle, and the interrupt stays set until it is cleared.
- R9: A write of any data to offset 0xC clears the interrupt on the next cycle.
- R10: If an underflow and a write to 0xC happen in the same cycle, the interrupt stays set.
- R11: Reading 0x8 returns bits 7, 6 and 3 as written and 0 in every other bit. Reading 0xC returns 0.
- R12: If a write to 0x0 coincides with a selected tick, the written value is loaded, no decrement or underflow happens, and the interrupt is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset of the register accessed |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the register at busAddr |
| tickSlow | input | 1 | Slow tick enable, one cycle per tick |
| tickFast | input | 1 | Fast tick enable, one cycle per tick |
| irq | output | 1 | Level interrupt, set on underflow |

## Verification
Assertions check, on every cycle, the following rules on the counter:

- it holds when no tick is gated through
- it decrements by one on a tick
- on underflow it reloads in periodic mode or wraps in free-running mode
- a start-value write wins over a tick

They also check that an underflow always leaves the interrupt set and that a clear with no underflow drops it.

The following can only be shown by the bench's scenarios, seen at the ports:

- that the tick source select and the enable bit route the right input
- that the control readback masks unused bits
- that a clear coinciding with an underflow is lost
- that the register readback agrees with a reference model over long random mixes of writes and ticks

// File: rtl/dctimer_pkg.sv
package dctimer_pkg;
  // Register byte offsets within the channel
  localparam logic [3:0] OFF_START = 4'h0;
  localparam logic [3:0] OFF_COUNT = 4'h4;
  localparam logic [3:0] OFF_CTRL  = 4'h8;
  localparam logic [3:0] OFF_CLEAR = 4'hC;

  // Control bit positions
  localparam int BIT_EN   = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_FAST = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic startWr;
    logic tickEn;
    logic periodic;
  } dpStrobe_t;
endpackage

// File: rtl/dctimer_dp.sv
module dctimer_dp
  import dctimer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [WIDTH-1:0] startData,
  output logic [WIDTH-1:0] countVal,
  output logic [WIDTH-1:0] startVal,
  output logic             underflow
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] startQ;
  logic             atZero;

  assign atZero    = (countQ == '0);
  assign underflow = stb.tickEn && !stb.startWr && atZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      startQ <= '0;
    end else if (stb.startWr) begin
      startQ <= startData;
      countQ <= startData;
    end else if (stb.tickEn) begin
      if (atZero) countQ <= stb.periodic ? startQ : ALL_ONES;
      else        countQ <= countQ - 1'b1;
    end
  end

  assign countVal = countQ;
  assign startVal = startQ;

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tickEn && !stb.startWr) |=> $stable(countQ));
  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tickEn && !stb.startWr && countQ != '0) |=> (countQ == $past(countQ) - 1'b1));
  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tickEn && !stb.startWr && countQ == '0 && stb.periodic) |=> (countQ == $past(startQ)));
  // R7
  free_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tickEn && !stb.startWr && countQ == '0 && !stb.periodic) |=> (countQ == ALL_ONES));
  // R12
  start_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.startWr |=> (countQ == $past(startData) && startQ == $past(startData)));
endmodule

// File: rtl/dctimer_ctrl.sv
module dctimer_ctrl
  import dctimer_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              tickSlow,
  input  logic              tickFast,
  input  logic              underflow,
  input  logic [WIDTH-1:0]  countVal,
  input  logic [WIDTH-1:0]  startVal,
  output dpStrobe_t         stb,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  logic enQ, perQ, fastQ, irqQ;
  logic ctrlWr, clearWr, tickSel;

  assign ctrlWr  = busWrEn && (busAddr == OFF_CTRL[ADDR_W-1:0]);
  assign clearWr = busWrEn && (busAddr == OFF_CLEAR[ADDR_W-1:0]);
  assign tickSel = fastQ ? tickFast : tickSlow;

  assign stb.startWr  = busWrEn && (busAddr == OFF_START[ADDR_W-1:0]);
  assign stb.tickEn   = enQ && tickSel;
  assign stb.periodic = perQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      perQ  <= 1'b0;
      fastQ <= 1'b0;
    end else if (ctrlWr) begin
      enQ   <= busWrData[BIT_EN];
      perQ  <= busWrData[BIT_PER];
      fastQ <= busWrData[BIT_FAST];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          irqQ <= 1'b0;
    else if (underflow) irqQ <= 1'b1;
    else if (clearWr)   irqQ <= 1'b0;
  end
  assign irq = irqQ;

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      OFF_START[ADDR_W-1:0]: busRdData[WIDTH-1:0] = startVal;
      OFF_COUNT[ADDR_W-1:0]: busRdData[WIDTH-1:0] = countVal;
      OFF_CTRL[ADDR_W-1:0]: begin
        busRdData[BIT_EN]   = enQ;
        busRdData[BIT_PER]  = perQ;
        busRdData[BIT_FAST] = fastQ;
      end
      default: busRdData = '0;
    endcase
  end

  // R8
  underflow_sets_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> irq);
  // R9
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && !underflow) |=> !irq);
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clearWr) |=> irq);
endmodule

// File: rtl/dctimer_chan.sv
module dctimer_chan
  import dctimer_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              tickSlow,
  input  logic              tickFast,
  output logic              irq
);
  dpStrobe_t        stb;
  logic [WIDTH-1:0] countVal, startVal;
  logic             underflow;

  dctimer_ctrl #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .tickSlow(tickSlow), .tickFast(tickFast),
    .underflow(underflow), .countVal(countVal), .startVal(startVal),
    .stb(stb), .busRdData(busRdData), .irq(irq)
  );

  dctimer_dp #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .startData(busWrData[WIDTH-1:0]),
    .countVal(countVal), .startVal(startVal), .underflow(underflow)
  );
endmodule

// File: tb/dctimer_chan_tb_top.sv
module dctimer_chan_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        tickSlow = 1'b0, tickFast = 1'b0;
  logic        irq;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Reference model state
  logic [15:0] mCount = '0, mStart = '0;
  logic mEn = 0, mPer = 0, mFast = 0, mIrq = 0;

  always #4 clk = ~clk;

  dctimer_chan #(.WIDTH(16), .ADDR_W(4), .DATA_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tickSlow(tickSlow),
    .tickFast(tickFast), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input bit wr, input logic [3:0] a, input logic [31:0] d,
                           input bit ts, input bit tf);
    bit tick, sw, uf;
    tick = mEn && (mFast ? tf : ts);
    sw   = wr && a == 4'h0;
    uf   = tick && !sw && mCount == 16'h0;
    if (sw) begin mStart = d[15:0]; mCount = d[15:0]; end
    else if (tick) mCount = (mCount == 16'h0) ? (mPer ? mStart : 16'hFFFF) : mCount - 16'h1;
    if (wr && a == 4'h8) begin mEn = d[7]; mPer = d[6]; mFast = d[3]; end
    if (uf) mIrq = 1;
    else if (wr && a == 4'hC) mIrq = 0;
  endtask

  // Called at a negedge; returns at the following negedge
  task automatic cyc(input bit wr, input logic [3:0] a, input logic [31:0] d,
                     input bit ts, input bit tf);
    busWrEn = wr; busAddr = a; busWrData = d; tickSlow = ts; tickFast = tf;
    @(posedge clk);
    modelStep(wr, a, d, ts, tf);
    @(negedge clk);
    busWrEn = 0; tickSlow = 0; tickFast = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    busAddr = a; #1; v = busRdData;
  endtask

  task automatic chkReg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    chkReg("R1 start", 4'h0, 0);
    chkReg("R1 count", 4'h4, 0);
    chkReg("R1 ctrl",  4'h8, 0);
    check("R1 irq", {31'b0, irq}, 0);
    // R2
    cyc(1, 4'h0, 32'hABCD0005, 0, 0);
    chkReg("R2 start", 4'h0, 32'h5);
    chkReg("R2 count", 4'h4, 32'h5);
    // R11
    cyc(1, 4'h8, 32'hFFFFFFFF, 0, 0);
    chkReg("R11 ctrl mask", 4'h8, 32'hC8);
    chkReg("R11 clear reads 0", 4'hC, 0);
    cyc(1, 4'h8, 0, 0, 0);
    chkReg("R11 ctrl zero", 4'h8, 0);
    // R3
    repeat (3) cyc(0, 4'h4, 0, 1, 1);
    chkReg("R3 hold", 4'h4, 32'h5);
    // R4 slow selected, fast ignored
    cyc(1, 4'h8, 32'h80, 0, 0);
    repeat (2) cyc(0, 4'h4, 0, 0, 1);
    chkReg("R4 fast ignored", 4'h4, 32'h5);
    cyc(0, 4'h4, 0, 1, 0);
    chkReg("R4 slow counts", 4'h4, 32'h4);
    cyc(1, 4'h8, 32'h88, 0, 0);
    cyc(0, 4'h4, 0, 1, 0);
    chkReg("R4 slow ignored", 4'h4, 32'h4);
    cyc(0, 4'h4, 0, 0, 1);
    chkReg("R4 fast counts", 4'h4, 32'h3);
    // R5
    repeat (3) cyc(0, 4'h4, 0, 0, 1);
    chkReg("R5 reach zero", 4'h4, 0);
    check("R5 no irq yet", {31'b0, irq}, 0);
    // R7 and R8
    cyc(0, 4'h4, 0, 0, 1);
    chkReg("R7 wrap", 4'h4, 32'hFFFF);
    check("R8 irq set", {31'b0, irq}, 1);
    repeat (3) cyc(0, 4'h4, 0, 0, 0);
    check("R8 irq held", {31'b0, irq}, 1);
    // R9
    cyc(1, 4'hC, 32'h1234, 0, 0);
    check("R9 clear", {31'b0, irq}, 0);
    // R6
    cyc(1, 4'h0, 32'h2, 0, 0);
    cyc(1, 4'h8, 32'hC8, 0, 0);
    repeat (2) cyc(0, 4'h4, 0, 0, 1);
    chkReg("R6 at zero", 4'h4, 0);
    cyc(0, 4'h4, 0, 0, 1);
    chkReg("R6 reload", 4'h4, 32'h2);
    check("R8 periodic irq", {31'b0, irq}, 1);
    cyc(1, 4'hC, 0, 0, 0);
    check("R9 clear again", {31'b0, irq}, 0);
    // R10
    repeat (2) cyc(0, 4'h4, 0, 0, 1);
    cyc(1, 4'hC, 32'h7, 0, 1);
    check("R10 irq survives clear", {31'b0, irq}, 1);
    chkReg("R10 reload", 4'h4, 32'h2);
    cyc(1, 4'hC, 0, 0, 0);
    // R12
    cyc(1, 4'h0, 32'h0, 0, 0);
    cyc(1, 4'h0, 32'h9, 0, 1);
    chkReg("R12 start wins", 4'h4, 32'h9);
    check("R12 no irq", {31'b0, irq}, 0);
    // Random mix against the model
    for (int i = 0; i < 4000; i++) begin
      bit wr;
      logic [3:0] a;
      logic [31:0] d;
      wr = ($urandom % 8) == 0;
      a  = 4'(($urandom % 4) * 4);
      d  = $urandom;
      if (a == 4'h0) d = d & 32'h1F;
      cyc(wr, a, d, 1'($urandom % 2), 1'($urandom % 2));
      chkReg("R5 random count", 4'h4, {16'h0, mCount});
      if (i % 16 == 0) chkReg("R2 random start", 4'h0, {16'h0, mStart});
      if (i % 16 == 8) chkReg("R11 random ctrl", 4'h8, {24'h0, mEn, mPer, 2'b00, mFast, 3'b000});
      check("R8 random irq", {31'b0, irq}, {31'b0, mIrq});
    end
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule